// File: doc/BRIEF.md
# I2C Target Byte Responder

This block is the target side of an I2C port. It is driven by software through a small register bus and reports progress one byte at a time. Each time a bus event needs attention, the engine raises an interrupt flag and posts an 8-bit status code. Software then reads or loads the data register and clears the flag, and the engine moves on to the next byte. While the flag is pending after an address or data phase, the engine holds SCL low, so the master waits for software.

The engine compares the first byte after a START with a programmable 7-bit own address. It also recognises the general-call address. Both bus lines are sampled through a two-stage synchroniser. START and STOP are detected as SDA edges while SCL is high. The open-drain pads are modelled as drive-low enables, so the pad is released when its enable is 0.

Top module: `i2c_tgt_responder`

## Requirements
- R1: After reset the control bits read 0, status reads 0xF8, and neither SCL nor SDA is driven.
- R2: Registers sit at these offsets. Writing offset 0 sets the control bits given by the 1s in the written value, and writing offset 1 clears them. Reading offset 0 returns the control bits. The control bits are: bit0 ack-enable, bit1 interrupt flag, bit2 stop-request, bit3 start-request. Offset 2 reads the status code, which is 0xF8 whenever the interrupt flag is clear. Offset 3 is the data register. Offset 4 is the own-address register, with the address in bits 7:1; bit 0 is ignored in the compare.
- R3: The engine answers its address only while ack-enable is 1 and both start-request and stop-request are 0. Otherwise it leaves the address byte unacknowledged, raises no flag and drives nothing.
- R4: When the address byte equals {own address, 0}, the engine ACKs it. It then raises the flag with status 0x60.
- R5: When the address byte is 0x00 (general call), the engine ACKs it and raises the flag with status 0x70.
- R6: When the address byte equals {own address, 1}, the engine ACKs it and raises the flag with status 0xA8.
- R7: Each data byte written to the engine is ACKed while ack-enable is 1. The byte is stored in the data register with status 0x80, or 0x90 when the transfer was opened by a general call.
- R8: A STOP or a repeated START while the engine is addressed gives status 0xA0, and SCL is not held for this event.
- R9: After 0xA8 or 0xB8, clearing the flag sends the data register MSB first. A master ACK with ack-enable 1 gives 0xB8. A master NACK gives 0xC0. A master ACK with ack-enable 0 gives 0xC8. After 0xC0 or 0xC8, SDA is released and the engine waits for a new address, so a later STOP posts no event.
- R10: SCL is held low while the flag is set after events 0x60, 0x70, 0xA8, 0x80, 0x90 and 0xB8. It is released once software clears the flag.
- R11: Any other address byte gets no ACK and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on reg_addr_i) |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The hardest cases to reach from the ports are the transmit endings. A 0xC8 needs software to drop ack-enable in the same window in which it clears the flag for the final byte. The master must then still ACK that byte, and a following STOP must post nothing. The bench models a bit-level master on wired-AND lines that respects clock stretching. It reaches this case by clearing ack-enable and the flag in one register write, then ACKing the byte. Around this, a sweep offers all 256 address bytes against one own address, and each address byte gets its acknowledge, status and stretch checked.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  // register offsets
  localparam logic [2:0] RA_SET  = 3'd0;
  localparam logic [2:0] RA_CLR  = 3'd1;
  localparam logic [2:0] RA_STAT = 3'd2;
  localparam logic [2:0] RA_DATA = 3'd3;
  localparam logic [2:0] RA_OWN  = 3'd4;

  // control bit positions
  localparam int CB_AA  = 0;
  localparam int CB_SI  = 1;
  localparam int CB_STO = 2;
  localparam int CB_STA = 3;
  localparam int CB_N   = 4;

  // status codes
  localparam logic [7:0] SC_OWN_W   = 8'h60;
  localparam logic [7:0] SC_GC_W    = 8'h70;
  localparam logic [7:0] SC_RX_OWN  = 8'h80;
  localparam logic [7:0] SC_RX_GC   = 8'h90;
  localparam logic [7:0] SC_END     = 8'hA0;
  localparam logic [7:0] SC_OWN_R   = 8'hA8;
  localparam logic [7:0] SC_TX_ACK  = 8'hB8;
  localparam logic [7:0] SC_TX_NACK = 8'hC0;
  localparam logic [7:0] SC_TX_LAST = 8'hC8;
  localparam logic [7:0] SC_NONE    = 8'hF8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TXW, ST_TX, ST_TACK
  } eng_state_e;
endpackage

// File: rtl/i2c_tgt_linemon.sv
module i2c_tgt_linemon #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p, scl_s, sda_s;

  generate
    if (STAGES < 2) begin : g_bad
      initial $fatal(1, "STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s   = scl_ff[STAGES-1];
  assign sda_s   = sda_ff[STAGES-1];
  assign sda_o   = sda_s;
  assign start_o = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o  = scl_s & scl_p & ~sda_p & sda_s;
  assign rise_o  = scl_s & ~scl_p;
  assign fall_o  = ~scl_s & scl_p;
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ev_i,
  input  logic [7:0]    ev_code_i,
  input  logic          ev_hold_i,
  input  logic          ev_wd_i,
  input  logic [DW-1:0] ev_data_i,
  output logic          ack_en_o,
  output logic          sta_o,
  output logic          sto_o,
  output logic          si_o,
  output logic          hold_o,
  output logic [DW-1:0] own_o,
  output logic [DW-1:0] txd_o
);
  logic [CB_N-1:0] ctrl_q;
  logic [7:0]      stat_q;
  logic            hold_q;
  logic [DW-1:0]   data_q, own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= SC_NONE;
      hold_q <= 1'b0;
      data_q <= '0;
      own_q  <= '0;
    end else begin
      if (we_i) begin
        case (addr_i)
          AW'(RA_SET):  ctrl_q <= ctrl_q | wdata_i[CB_N-1:0];
          AW'(RA_CLR):  ctrl_q <= ctrl_q & ~wdata_i[CB_N-1:0];
          AW'(RA_DATA): data_q <= wdata_i;
          AW'(RA_OWN):  own_q  <= wdata_i;
          default: ;
        endcase
      end
      // engine events take priority over software
      if (ev_i) begin
        ctrl_q[CB_SI] <= 1'b1;
        stat_q        <= ev_code_i;
        hold_q        <= ev_hold_i;
        if (ev_wd_i) data_q <= ev_data_i;
      end
    end
  end

  always_comb begin
    case (addr_i)
      AW'(RA_SET):  rdata_o = DW'(ctrl_q);
      AW'(RA_STAT): rdata_o = DW'(ctrl_q[CB_SI] ? stat_q : SC_NONE);
      AW'(RA_DATA): rdata_o = data_q;
      AW'(RA_OWN):  rdata_o = own_q;
      default:      rdata_o = '0;
    endcase
  end

  assign ack_en_o = ctrl_q[CB_AA];
  assign sta_o    = ctrl_q[CB_STA];
  assign sto_o    = ctrl_q[CB_STO];
  assign si_o     = ctrl_q[CB_SI];
  assign hold_o   = hold_q;
  assign own_o    = own_q;
  assign txd_o    = data_q;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          sda_i,
  input  logic          ack_en_i,
  input  logic          sta_i,
  input  logic          sto_i,
  input  logic          si_i,
  input  logic [DW-2:0] own_i,
  input  logic [DW-1:0] txd_i,
  output logic          sda_oe_o,
  output logic          ev_o,
  output logic [7:0]    ev_code_o,
  output logic          ev_hold_o,
  output logic          ev_wd_o,
  output logic [DW-1:0] ev_data_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  eng_state_e    st_q;
  logic [DW-1:0] sh_q;
  logic [CW-1:0] cnt_q;
  logic rd_q, gc_q, mack_q, armed_q, sda_oe_q;
  logic ev_q, ev_hold_q, ev_wd_q;
  logic [7:0]    ev_code_q;
  logic [DW-1:0] ev_data_q;
  logic addressed, gc_hit, own_hit, may_ack;

  assign addressed = !(st_q == ST_IDLE || st_q == ST_ADDR);
  assign gc_hit    = (sh_q[DW-1:1] == '0) && !sh_q[0];
  assign own_hit   = (sh_q[DW-1:1] == own_i);
  assign may_ack   = ack_en_i && !sta_i && !sto_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      rd_q      <= 1'b0;
      gc_q      <= 1'b0;
      mack_q    <= 1'b0;
      armed_q   <= 1'b0;
      sda_oe_q  <= 1'b0;
      ev_q      <= 1'b0;
      ev_hold_q <= 1'b0;
      ev_wd_q   <= 1'b0;
      ev_code_q <= SC_NONE;
      ev_data_q <= '0;
    end else begin
      ev_q    <= 1'b0;
      ev_wd_q <= 1'b0;
      if (start_i) begin
        if (addressed) begin
          ev_q      <= 1'b1;
          ev_code_q <= SC_END;
          ev_hold_q <= 1'b0;
        end
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_i) begin
        if (addressed) begin
          ev_q      <= 1'b1;
          ev_code_q <= SC_END;
          ev_hold_q <= 1'b0;
        end
        st_q     <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_RX: begin
            if (rise_i) begin
              sh_q  <= {sh_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (fall_i && cnt_q == LAST) begin
              if (st_q == ST_ADDR) begin
                if (may_ack && (gc_hit || own_hit)) begin
                  sda_oe_q <= 1'b1;
                  rd_q     <= sh_q[0] & ~gc_hit;
                  gc_q     <= gc_hit;
                  st_q     <= ST_AACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else if (ack_en_i) begin
                sda_oe_q <= 1'b1;
                st_q     <= ST_RACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (fall_i) begin
            sda_oe_q  <= 1'b0;
            ev_q      <= 1'b1;
            ev_hold_q <= 1'b1;
            ev_code_q <= rd_q ? SC_OWN_R : (gc_q ? SC_GC_W : SC_OWN_W);
            st_q      <= rd_q ? ST_TXW : ST_RX;
            cnt_q     <= '0;
            armed_q   <= 1'b0;
          end
          ST_RACK: if (fall_i) begin
            sda_oe_q  <= 1'b0;
            ev_q      <= 1'b1;
            ev_hold_q <= 1'b1;
            ev_wd_q   <= 1'b1;
            ev_data_q <= sh_q;
            ev_code_q <= gc_q ? SC_RX_GC : SC_RX_OWN;
            st_q      <= ST_RX;
            cnt_q     <= '0;
          end
          ST_TXW: begin
            // flag is registered one cycle after the event
            if (!armed_q) begin
              armed_q <= 1'b1;
            end else if (!si_i) begin
              sh_q     <= txd_i;
              sda_oe_q <= ~txd_i[DW-1];
              cnt_q    <= CW'(1);
              st_q     <= ST_TX;
            end
          end
          ST_TX: if (fall_i) begin
            if (cnt_q == LAST) begin
              sda_oe_q <= 1'b0;
              st_q     <= ST_TACK;
            end else begin
              sh_q     <= sh_q << 1;
              sda_oe_q <= ~sh_q[DW-2];
              cnt_q    <= cnt_q + 1'b1;
            end
          end
          ST_TACK: begin
            if (rise_i) mack_q <= ~sda_i;
            else if (fall_i) begin
              ev_q    <= 1'b1;
              armed_q <= 1'b0;
              if (!mack_q) begin
                ev_code_q <= SC_TX_NACK;
                ev_hold_q <= 1'b0;
                st_q      <= ST_IDLE;
              end else if (ack_en_i) begin
                ev_code_q <= SC_TX_ACK;
                ev_hold_q <= 1'b1;
                st_q      <= ST_TXW;
              end else begin
                ev_code_q <= SC_TX_LAST;
                ev_hold_q <= 1'b0;
                st_q      <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o  = sda_oe_q;
  assign ev_o      = ev_q;
  assign ev_code_o = ev_code_q;
  assign ev_hold_o = ev_hold_q;
  assign ev_wd_o   = ev_wd_q;
  assign ev_data_o = ev_data_q;
endmodule

// File: rtl/i2c_tgt_responder.sv
module i2c_tgt_responder #(
  parameter int DW          = 8,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o
);
  logic sda_s, start_det, stop_det, scl_rise, scl_fall;
  logic ack_en, sta, sto, si, hold;
  logic ev, ev_hold, ev_wd;
  logic [7:0]    ev_code;
  logic [DW-1:0] ev_data, own_q, data_q;

  i2c_tgt_linemon #(.STAGES(SYNC_STAGES)) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .start_o(start_det), .stop_o(stop_det),
    .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_tgt_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ev_i(ev), .ev_code_i(ev_code), .ev_hold_i(ev_hold), .ev_wd_i(ev_wd),
    .ev_data_i(ev_data), .ack_en_o(ack_en), .sta_o(sta), .sto_o(sto),
    .si_o(si), .hold_o(hold), .own_o(own_q), .txd_o(data_q)
  );

  i2c_tgt_engine #(.DW(DW)) u_eng (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_det), .stop_i(stop_det),
    .rise_i(scl_rise), .fall_i(scl_fall), .sda_i(sda_s),
    .ack_en_i(ack_en), .sta_i(sta), .sto_i(sto), .si_i(si),
    .own_i(own_q[DW-1:1]), .txd_i(data_q), .sda_oe_o(sda_oe_o),
    .ev_o(ev), .ev_code_o(ev_code), .ev_hold_o(ev_hold), .ev_wd_o(ev_wd),
    .ev_data_o(ev_data)
  );

  assign scl_oe_o = si & hold;
endmodule

// File: rtl/i2c_tgt_responder_chk.sv
module i2c_tgt_responder_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_oe_o,
  input logic          sda_oe_o,
  input logic          si,
  input logic          ack_en,
  input logic          ev,
  input logic [7:0]    ev_code,
  input logic          stop_det,
  input logic [DW-1:0] data_q,
  input logic [DW-1:0] ev_data
);
  p_hold_needs_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> si);

  p_addr_ack_needs_aa_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev && (ev_code == 8'h60 || ev_code == 8'h70 || ev_code == 8'hA8)) |-> ack_en);

  p_event_raises_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev |=> si);

  p_stop_frees_sda_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  p_end_not_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev && ev_code == 8'hA0) |=> !scl_oe_o);

  p_rx_byte_stored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev && (ev_code == 8'h80 || ev_code == 8'h90)) |=> data_q == $past(ev_data));
endmodule

bind i2c_tgt_responder i2c_tgt_responder_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
  .si(si), .ack_en(ack_en), .ev(ev), .ev_code(ev_code), .stop_det(stop_det),
  .data_q(data_q), .ev_data(ev_data)
);

// File: tb/i2c_tgt_responder_bench.sv
module i2c_tgt_responder_bench;
  localparam int H = 8;
  localparam logic [7:0] OWN = 8'hB5;   // bit0 ignored -> address 0x5A
  localparam logic [6:0] ME  = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic we = 1'b0;
  logic [2:0] ra = 3'd0;
  logic [7:0] wd = 8'd0, rd;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, scl_l, sda_l;
  assign scl_l = scl_m & ~scl_oe;
  assign sda_l = sda_m & ~sda_oe;

  int vec = 0, bad = 0, cyc = 0;
  logic done = 1'b0;

  i2c_tgt_responder u_i2c_tgt_responder (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .scl_i(scl_l), .sda_i(sda_l),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; ra = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); ra = a; #1 v = rd;
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic scl_up();
    scl_m = 1'b1;
    do @(negedge clk); while (!scl_l);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; half(); scl_up(); half();
    r = sda_l; scl_m = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; half(); scl_up(); half();
    sda_m = 1'b0; half(); scl_m = 1'b0; half();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; half(); scl_up(); half();
    sda_m = 1'b1; half();
  endtask

  task automatic m_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) m_bit(b[i], r);
    m_bit(1'b1, r);
    ack = ~r;
    half();
  endtask

  task automatic m_rbyte(input logic nack, output logic [7:0] v);
    logic r;
    v = '0;
    for (int i = 0; i < 8; i++) begin m_bit(1'b1, r); v = {v[6:0], r}; end
    m_bit(nack, r);
    half();
  endtask

  task automatic chk_stat(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    reg_rd(3'd2, v);
    chk(tag, int'(v), int'(exp));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic ack;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    reg_rd(3'd0, v); chk("R1 ctrl", int'(v), 0);
    chk_stat("R1 status", 8'hF8);
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);

    // R2 register behaviour
    reg_wr(3'd4, OWN); reg_rd(3'd4, v); chk("R2 own", int'(v), int'(OWN));
    reg_wr(3'd0, 8'h0F); reg_rd(3'd0, v); chk("R2 set", int'(v), 8'h0F);
    reg_wr(3'd1, 8'h0E); reg_rd(3'd0, v); chk("R2 clr", int'(v), 8'h01);
    chk_stat("R2 status no flag", 8'hF8);
    reg_wr(3'd3, 8'h3C); reg_rd(3'd3, v); chk("R2 data", int'(v), 8'h3C);

    // R4 R5 R6 R11 R10 R8: sweep every address byte
    for (int a = 0; a < 128; a++) begin
      for (int rw = 0; rw < 2; rw++) begin
        logic [7:0] b;
        logic exp_ack;
        logic [7:0] exp_st;
        b = {a[6:0], rw[0]};
        exp_ack = (a[6:0] == ME) || (a == 0 && rw == 0);
        exp_st = !exp_ack ? 8'hF8 : (rw == 1 ? 8'hA8 : (a == 0 ? 8'h70 : 8'h60));
        m_start();
        m_byte(b, ack);
        chk("R11 R4 R5 R6 ack", int'(ack), int'(exp_ack));
        chk_stat("R4 R5 R6 status", exp_st);
        chk("R10 stretch", int'(scl_oe), int'(exp_ack));
        if (exp_ack) begin
          if (rw == 1) reg_wr(3'd3, 8'hFF);
          reg_wr(3'd1, 8'h02);
          chk("R10 release", int'(scl_oe), 0);
          m_stop();
          chk_stat("R8 stop", 8'hA0);
          chk("R8 no hold", int'(scl_oe), 0);
          reg_wr(3'd1, 8'h02);
        end else begin
          m_stop();
          chk_stat("R11 idle", 8'hF8);
        end
      end
    end

    // R3 no response when disabled or a request bit is set
    for (int k = 0; k < 3; k++) begin
      if (k == 0) reg_wr(3'd1, 8'h01);
      if (k == 1) reg_wr(3'd0, 8'h08);
      if (k == 2) reg_wr(3'd0, 8'h04);
      m_start(); m_byte({ME, 1'b0}, ack);
      chk("R3 no ack", int'(ack), 0);
      chk_stat("R3 no flag", 8'hF8);
      chk("R3 sda free", int'(sda_oe), 0);
      m_stop();
      reg_wr(3'd1, 8'h0C);
      reg_wr(3'd0, 8'h01);
    end

    // R7 received bytes
    m_start(); m_byte({ME, 1'b0}, ack);
    chk_stat("R7 addr", 8'h60);
    reg_wr(3'd1, 8'h02);
    for (int i = 0; i < 12; i++) begin
      logic [7:0] d;
      d = 8'((i * 37 + 11) ^ (i << 5));
      m_byte(d, ack);
      chk("R7 ack", int'(ack), 1);
      chk_stat("R7 status", 8'h80);
      reg_rd(3'd3, v); chk("R7 data", int'(v), int'(d));
      reg_wr(3'd1, 8'h02);
    end
    m_stop(); chk_stat("R8 end", 8'hA0); reg_wr(3'd1, 8'h02);

    m_start(); m_byte(8'h00, ack); chk_stat("R5 gc", 8'h70);
    reg_wr(3'd1, 8'h02);
    m_byte(8'h96, ack); chk("R7 gc ack", int'(ack), 1);
    chk_stat("R7 gc status", 8'h90);
    reg_rd(3'd3, v); chk("R7 gc data", int'(v), 8'h96);
    reg_wr(3'd1, 8'h02);
    m_stop(); chk_stat("R8 gc end", 8'hA0); reg_wr(3'd1, 8'h02);

    // R8 repeated start while addressed
    m_start(); m_byte({ME, 1'b0}, ack); chk_stat("R8 pre", 8'h60);
    reg_wr(3'd1, 8'h02);
    m_start();
    chk_stat("R8 rstart", 8'hA0);
    chk("R8 rstart hold", int'(scl_oe), 0);
    reg_wr(3'd1, 8'h02);
    m_byte(8'h20, ack); chk("R11 after rstart", int'(ack), 0);
    m_stop(); chk_stat("R8 idle stop", 8'hF8);

    // R9 transmit: ack, last byte, nack
    m_start(); m_byte({ME, 1'b1}, ack); chk_stat("R6 read", 8'hA8);
    reg_wr(3'd3, 8'hC3); reg_wr(3'd1, 8'h02);
    m_rbyte(1'b0, v); chk("R9 byte1", int'(v), 8'hC3);
    chk_stat("R9 B8", 8'hB8);
    chk("R10 hold B8", int'(scl_oe), 1);
    reg_wr(3'd3, 8'h5A); reg_wr(3'd1, 8'h03);
    m_rbyte(1'b0, v); chk("R9 byte2", int'(v), 8'h5A);
    chk_stat("R9 C8", 8'hC8);
    chk("R9 sda free C8", int'(sda_oe), 0);
    m_stop(); chk_stat("R9 no end after C8", 8'hC8);
    reg_wr(3'd1, 8'h02); reg_wr(3'd0, 8'h01);

    m_start(); m_byte({ME, 1'b1}, ack); chk_stat("R6 read2", 8'hA8);
    reg_wr(3'd3, 8'h81); reg_wr(3'd1, 8'h02);
    m_rbyte(1'b1, v); chk("R9 byte3", int'(v), 8'h81);
    chk_stat("R9 C0", 8'hC0);
    chk("R9 sda free C0", int'(sda_oe), 0);
    chk("R9 no hold C0", int'(scl_oe), 0);
    m_stop(); chk_stat("R9 no end after C0", 8'hC0);
    reg_wr(3'd1, 8'h02);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule